// File: doc/BRIEF.md
# External Bus Chip-Select Controller

This block sits on the host side of a multiplexed external parallel bus and turns single internal read or write requests into bus cycles for one programmable chip-select window. A request carries a 32-bit address, a data word and a size of one, two or four bytes. The address is checked against a base and a mask. A request that hits the window runs on the bus. A request that misses, or that arrives while the window is disabled, is answered at once with an error pulse and causes no bus activity.

Each bus access opens with an address phase: ALE is pulsed and the full address is driven on the shared address/data lines. Chip select follows after a programmable setup delay. Data phases last one clock plus a programmable number of wait states and are ended internally, so no acknowledge comes from the device. The external port is eight bits wide and uses the top byte lane. Wider accesses are split into byte beats with the most significant byte first. Depending on per-direction burst enables, these beats either share one address phase with chip select held low, or each beat repeats its own address phase with chip select released in between.

Configuration is loaded through a small write port with three register slots. The controller must not be reconfigured while an access is in progress.

Top module: `ebus_cs_ctrl`

## Requirements
- R1: The window hits when `((addr ^ base) & ~mask) == 0`. `mask` is the 16-bit mask field in bits 31:16 of config slot 1, with bits 15:0 forced to ones. Example: field 0x0007 with base 0x60000000 hits 0x60000000 to 0x6007FFFF, and misses 0x60080000. Config slot 0 holds the base.
- R2: While the valid bit (bit 0 of config slot 1) is clear, every request returns an error pulse and no bus cycle starts.
- R3: A request outside the window gives `rsp_err` high for exactly the one cycle after the request is sampled. ALE stays low, chip select stays high and `busy` stays low.
- R4: The setup field S (config slot 2, bits 1:0) places S clocks between the ALE clock and the first clock with chip select low. The address stays driven during those clocks.
- R5: The wait field W (config slot 2, bits 7:4) makes every data beat hold chip select low, or keep it low in a burst, for W+1 clocks.
- R6: Without burst, an access of n bytes runs n address/data pairs. The beat addresses are addr, addr+1, and so on, and chip select is high during each address phase.
- R7: With burst, one address phase carrying the start address is followed by n*(W+1) clocks of chip select held low.
- R8: A one-byte access produces identical bus activity whatever the burst bits are.
- R9: Bit 8 of config slot 2 enables burst for reads, and bit 9 enables burst for writes. Each bit affects only its own direction.
- R10: Data beats use `bus_ad_out[31:24]` with the other bits zero. Written bytes go out most significant first. The address phase drives all 32 bits.
- R11: Read bytes are sampled from `bus_ad_in[31:24]` on the last clock of each beat and packed big-endian, with the first byte most significant. The result is zero-extended for sizes 1 and 2. `rsp_done` pulses for one cycle, the cycle after the last data clock, with `rsp_rdata` valid and `busy` low.
- R12: ALE is high for one clock per address phase. OE is low only during read data clocks. R/W is high for reads and low for writes throughout an access. When idle, chip select, OE and R/W are high, ALE is low and the lines are not driven.
- R13: The size code `req_size` is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Slot select: 0 base, 1 mask/valid, 2 timing/burst |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request strobe, sampled while not busy |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | Size code (R13) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data, right-aligned |
| busy | output | 1 | Access in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle rejection pulse |
| rsp_rdata | output | 32 | Read result |
| bus_ad_out | output | 32 | Multiplexed address/data out |
| bus_ad_oe | output | 1 | Drive enable for bus_ad_out |
| bus_ad_in | input | 32 | Multiplexed data in |
| bus_ale | output | 1 | Address latch enable |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rw | output | 1 | 1 read, 0 write |
| bus_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions rely on two conditions. Requests are raised only while `busy` is low. Configuration slots are not written between the acceptance of a request and its `rsp_done`, because the setup, wait and burst fields are read live by the sequencer. The stimulus keeps to both: it issues one request at a time, waits for the completion or error pulse, and changes configuration only between accesses. Random configurations span every setup value, wait values 0 to 15, all four burst combinations and random mask fields. Random addresses fall mostly inside the window, so hits and misses are both exercised.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_SETUP = 2'd2,
    ST_DATA  = 2'd3
  } ebus_st_e;

  // configuration slot numbers
  localparam logic [1:0] SLOT_BASE = 2'd0;
  localparam logic [1:0] SLOT_MASK = 2'd1;
  localparam logic [1:0] SLOT_CTL  = 2'd2;

  // field positions inside the slots
  localparam int MSK_VALID_BIT = 0;
  localparam int CTL_SETUP_LSB = 0;
  localparam int CTL_WAIT_LSB  = 4;
  localparam int CTL_BR_BIT    = 8;
  localparam int CTL_BW_BIT    = 9;

  localparam int BEAT_W = 3;

  function automatic logic [BEAT_W-1:0] size_to_beats(input logic [1:0] sz);
    case (sz)
      2'd0:    return BEAT_W'(1);
      2'd1:    return BEAT_W'(2);
      default: return BEAT_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/ebus_cfg.sv
module ebus_cfg
  import ebus_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SETUP_W = 2,
  parameter int WAIT_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_sel,
  input  logic [DW-1:0]      cfg_wdata,
  output logic [DW-1:0]      base,
  output logic [DW-1:0]      mask,
  output logic               valid,
  output logic [SETUP_W-1:0] setup,
  output logic [WAIT_W-1:0]  waits,
  output logic               burst_rd,
  output logic               burst_wr
);
  localparam int HW = DW / 2;

  logic [HW-1:0] mfield_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base     <= '0;
      mfield_q <= '0;
      valid    <= 1'b0;
      setup    <= '0;
      waits    <= '0;
      burst_rd <= 1'b0;
      burst_wr <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SLOT_BASE: base <= cfg_wdata;
        SLOT_MASK: begin
          mfield_q <= cfg_wdata[DW-1:HW];
          valid    <= cfg_wdata[MSK_VALID_BIT];
        end
        SLOT_CTL: begin
          setup    <= cfg_wdata[CTL_SETUP_LSB +: SETUP_W];
          waits    <= cfg_wdata[CTL_WAIT_LSB +: WAIT_W];
          burst_rd <= cfg_wdata[CTL_BR_BIT];
          burst_wr <= cfg_wdata[CTL_BW_BIT];
        end
        default: ;
      endcase
    end
  end

  // low half is always a don't-care
  assign mask = {mfield_q, {HW{1'b1}}};

endmodule

// File: rtl/ebus_win.sv
module ebus_win #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] mask,
  input  logic          valid,
  output logic          hit
);
  assign hit = valid && (((addr ^ base) & ~mask) == '0);
endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int DW      = 32,
  parameter int SETUP_W = 2,
  parameter int WAIT_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_size,
  input  logic [DW-1:0]      req_addr,
  input  logic [DW-1:0]      req_wdata,
  input  logic               win_hit,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic               cfg_br,
  input  logic               cfg_bw,
  input  logic [DW-1:0]      bus_ad_in,
  output logic               busy,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [DW-1:0]      rsp_rdata,
  output logic [DW-1:0]      bus_ad_out,
  output logic               bus_ad_oe,
  output logic               bus_ale,
  output logic               bus_cs_n,
  output logic               bus_rw,
  output logic               bus_oe_n
);
  localparam int BYTES = DW / 8;
  localparam int CNT_W = (SETUP_W > WAIT_W) ? SETUP_W : WAIT_W;

  ebus_st_e          st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DW-1:0]     addr_q, addr_n, sh_q, sh_n, rd_q, rd_n;
  logic [BEAT_W-1:0] left_q, left_n, nb;
  logic              wr_q, wr_n, bst_q, bst_n, done_n, err_n;

  assign nb = size_to_beats(req_size);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    sh_n   = sh_q;
    rd_n   = rd_q;
    left_n = left_q;
    wr_n   = wr_q;
    bst_n  = bst_q;
    done_n = 1'b0;
    err_n  = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        if (win_hit) begin
          wr_n   = req_write;
          addr_n = req_addr;
          left_n = nb;
          sh_n   = req_wdata << (8 * (BYTES - int'(nb)));
          rd_n   = '0;
          bst_n  = (nb != BEAT_W'(1)) && (req_write ? cfg_bw : cfg_br);
          cnt_n  = '0;
          st_n   = ST_ADDR;
        end else begin
          err_n = 1'b1;
        end
      end
      ST_ADDR: begin
        cnt_n = '0;
        st_n  = (cfg_setup == '0) ? ST_DATA : ST_SETUP;
      end
      ST_SETUP: begin
        if ((cnt_q + CNT_W'(1)) == CNT_W'(cfg_setup)) begin
          cnt_n = '0;
          st_n  = ST_DATA;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      ST_DATA: begin
        if (cnt_q == CNT_W'(cfg_wait)) begin
          cnt_n  = '0;
          rd_n   = {rd_q[DW-9:0], bus_ad_in[DW-1 -: 8]};
          sh_n   = sh_q << 8;
          addr_n = addr_q + DW'(1);
          if (left_q == BEAT_W'(1)) begin
            st_n   = ST_IDLE;
            done_n = 1'b1;
          end else begin
            left_n = left_q - BEAT_W'(1);
            st_n   = bst_q ? ST_DATA : ST_ADDR;
          end
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      addr_q     <= '0;
      sh_q       <= '0;
      rd_q       <= '0;
      left_q     <= '0;
      wr_q       <= 1'b0;
      bst_q      <= 1'b0;
      rsp_done   <= 1'b0;
      rsp_err    <= 1'b0;
      bus_ale    <= 1'b0;
      bus_cs_n   <= 1'b1;
      bus_oe_n   <= 1'b1;
      bus_rw     <= 1'b1;
      bus_ad_oe  <= 1'b0;
      bus_ad_out <= '0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      addr_q    <= addr_n;
      sh_q      <= sh_n;
      rd_q      <= rd_n;
      left_q    <= left_n;
      wr_q      <= wr_n;
      bst_q     <= bst_n;
      rsp_done  <= done_n;
      rsp_err   <= err_n;
      // strobes decoded from the next state so they leave a flop
      bus_ale   <= (st_n == ST_ADDR);
      bus_cs_n  <= (st_n != ST_DATA);
      bus_oe_n  <= !((st_n == ST_DATA) && !wr_n);
      bus_rw    <= (st_n == ST_IDLE) ? 1'b1 : !wr_n;
      bus_ad_oe <= (st_n == ST_ADDR) || (st_n == ST_SETUP) ||
                   ((st_n == ST_DATA) && wr_n);
      if ((st_n == ST_ADDR) || (st_n == ST_SETUP))
        bus_ad_out <= addr_n;
      else if ((st_n == ST_DATA) && wr_n)
        bus_ad_out <= {sh_n[DW-1 -: 8], {(DW-8){1'b0}}};
      else
        bus_ad_out <= '0;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign rsp_rdata = rd_q;

  // R7: in a burst, chip select is held until the access completes
  a_r7_burst_cs_held: assert property (@(posedge clk) disable iff (rst)
    (bst_q && !bus_cs_n) |=> (!bus_cs_n || rsp_done));

  // R6: the address phase never overlaps chip select
  a_r6_ale_cs_apart: assert property (@(posedge clk) disable iff (rst)
    bus_ale |-> bus_cs_n);

  // R12: ALE lasts a single clock
  a_r12_ale_one_clk: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale);

  // R12: OE only in read data clocks, lines released
  a_r12_oe_read_only: assert property (@(posedge clk) disable iff (rst)
    !bus_oe_n |-> (bus_rw && !bus_cs_n && !bus_ad_oe));

  // R12: direction steady across an access
  a_r12_rw_steady: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(bus_rw));

  // R3: rejection leaves the bus quiet
  a_r3_err_quiet: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (!busy && bus_cs_n && !bus_ale));

  // R11: completion and rejection never coincide
  a_r11_done_err_apart: assert property (@(posedge clk) disable iff (rst)
    !(rsp_done && rsp_err));

endmodule

// File: rtl/ebus_cs_ctrl.sv
module ebus_cs_ctrl #(
  parameter int DW      = 32,
  parameter int SETUP_W = 2,
  parameter int WAIT_W  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] bus_ad_out,
  output logic          bus_ad_oe,
  input  logic [DW-1:0] bus_ad_in,
  output logic          bus_ale,
  output logic          bus_cs_n,
  output logic          bus_rw,
  output logic          bus_oe_n
);
  logic [DW-1:0]      base, mask;
  logic               valid, hit, br, bw;
  logic [SETUP_W-1:0] setup;
  logic [WAIT_W-1:0]  waits;

  ebus_cfg #(.DW(DW), .SETUP_W(SETUP_W), .WAIT_W(WAIT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .base(base), .mask(mask), .valid(valid),
    .setup(setup), .waits(waits), .burst_rd(br), .burst_wr(bw)
  );

  ebus_win #(.DW(DW)) u_win (
    .addr(req_addr), .base(base), .mask(mask), .valid(valid), .hit(hit)
  );

  ebus_seq #(.DW(DW), .SETUP_W(SETUP_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .win_hit(hit), .cfg_setup(setup), .cfg_wait(waits), .cfg_br(br),
    .cfg_bw(bw), .bus_ad_in(bus_ad_in), .busy(busy), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n),
    .bus_rw(bus_rw), .bus_oe_n(bus_oe_n)
  );

endmodule

// File: tb/tb_ebus_cs_ctrl.sv
module tb_ebus_cs_ctrl;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, cfg_we, req_valid, req_write;
  logic [1:0]  cfg_sel, req_size;
  logic [31:0] cfg_wdata, req_addr, req_wdata, bus_ad_in;
  logic        busy, rsp_done, rsp_err, bus_ad_oe, bus_ale, bus_cs_n, bus_rw, bus_oe_n;
  logic [31:0] rsp_rdata, bus_ad_out;

  ebus_cs_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .bus_ad_out(bus_ad_out),
    .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in), .bus_ale(bus_ale),
    .bus_cs_n(bus_cs_n), .bus_rw(bus_rw), .bus_oe_n(bus_oe_n)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench copy of the configuration
  logic [31:0] b_base;
  logic [15:0] b_mfield;
  bit b_valid, b_br, b_bw;
  int b_setup, b_wait;

  // expected per-clock trace
  logic e_ale [128], e_csn [128], e_oen [128], e_adoe [128];
  logic [31:0] e_ad [128];
  int e_beat [128];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // slot 1: [31:16] mask field, [0] valid; slot 2: [1:0] setup, [7:4] wait, [8] rd burst, [9] wr burst
  task automatic set_cfg(logic [31:0] base, logic [15:0] mf, bit v, int s, int w, bit br, bit bw);
    b_base = base; b_mfield = mf; b_valid = v; b_setup = s; b_wait = w; b_br = br; b_bw = bw;
    cfg_wr(2'd0, base);
    cfg_wr(2'd1, {mf, 15'd0, v});
    cfg_wr(2'd2, {22'd0, bw, br, 4'(w), 2'd0, 2'(s)});
  endtask

  function automatic int beats_of(logic [1:0] sz);  // R13
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit exp_hit(logic [31:0] a);  // R1
    return b_valid && (((a ^ b_base) & ~{b_mfield, 16'hFFFF}) == 32'd0);
  endfunction

  task automatic access(bit wr, logic [31:0] addr, logic [31:0] wd, logic [1:0] sz);
    int n, len;
    bit bst, hit, ok;
    logic [7:0] rb [4];
    logic [31:0] erd, av, ev;
    string tag, what;
    n = beats_of(sz);
    hit = exp_hit(addr);
    bst = (n > 1) && (wr ? b_bw : b_br);  // R9, R8
    erd = 32'd0;
    for (int b = 0; b < n; b++) begin
      rb[b] = 8'($urandom);
      erd = (erd << 8) | {24'd0, rb[b]};  // R11
    end
    // build expected clocks: R4 setup, R5 wait, R6/R7 sequencing, R10 lanes
    len = 0;
    for (int b = 0; b < n; b++) begin
      if (b == 0 || !bst) begin
        for (int s = 0; s <= b_setup; s++) begin
          e_ale[len] = (s == 0); e_csn[len] = 1'b1; e_oen[len] = 1'b1; e_adoe[len] = 1'b1;
          e_ad[len] = addr + (bst ? 32'd0 : 32'(b)); e_beat[len] = b; len++;
        end
      end
      for (int w = 0; w <= b_wait; w++) begin
        e_ale[len] = 1'b0; e_csn[len] = 1'b0; e_oen[len] = wr; e_adoe[len] = wr;
        e_ad[len] = {8'(wd >> (8 * (n - 1 - b))), 24'd0}; e_beat[len] = b; len++;
      end
    end
    tag = !hit ? (b_valid ? "R3" : "R2") : bst ? "R7" : (n > 1 ? "R6" : "R8");

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd; req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    if (!hit) begin
      chk(rsp_err && bus_cs_n && !bus_ale && !busy, tag, "error pulse, bus quiet",
          {28'd0, rsp_err, bus_cs_n, bus_ale, busy}, 32'hC);
      @(negedge clk);
      chk(!rsp_err && bus_cs_n && !busy, tag, "error pulse one clock",
          {29'd0, rsp_err, bus_cs_n, busy}, 32'h2);
      return;
    end
    ok = 1; what = ""; av = 0; ev = 0;
    for (int c = 0; c < len; c++) begin
      bus_ad_in = {rb[e_beat[c]], 24'd0};
      if (ok) begin
        if (bus_ale !== e_ale[c]) begin ok = 0; what = $sformatf("clk %0d ale (R12)", c); av = 32'(bus_ale); ev = 32'(e_ale[c]); end
        else if (bus_cs_n !== e_csn[c]) begin ok = 0; what = $sformatf("clk %0d cs_n (R4/R5)", c); av = 32'(bus_cs_n); ev = 32'(e_csn[c]); end
        else if (bus_oe_n !== e_oen[c]) begin ok = 0; what = $sformatf("clk %0d oe_n (R12)", c); av = 32'(bus_oe_n); ev = 32'(e_oen[c]); end
        else if (bus_rw !== !wr) begin ok = 0; what = $sformatf("clk %0d rw (R12)", c); av = 32'(bus_rw); ev = 32'(!wr); end
        else if (bus_ad_oe !== e_adoe[c]) begin ok = 0; what = $sformatf("clk %0d ad_oe", c); av = 32'(bus_ad_oe); ev = 32'(e_adoe[c]); end
        else if (e_adoe[c] && bus_ad_out !== e_ad[c]) begin ok = 0; what = $sformatf("clk %0d ad (R10)", c); av = bus_ad_out; ev = e_ad[c]; end
        else if (rsp_done || rsp_err || !busy) begin ok = 0; what = $sformatf("clk %0d early response", c); av = {30'd0, rsp_done, rsp_err}; ev = 0; end
      end
      @(negedge clk);
    end
    chk(ok, tag, what, av, ev);
    // R11 completion pulse and data
    chk(rsp_done && !busy && bus_cs_n, "R11", "done after last data clock",
        {29'd0, rsp_done, busy, bus_cs_n}, 32'h5);
    if (!wr) chk(rsp_rdata == erd, "R11", "read data", rsp_rdata, erd);
    @(negedge clk);
    chk(!rsp_done, "R11", "done lasts one clock", 32'(rsp_done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    void'($urandom(32'h5EED1));
    rst = 1'b1; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 32'd0;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0; req_addr = 32'd0;
    req_wdata = 32'd0; bus_ad_in = 32'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 idle levels after reset
    chk(!busy && bus_cs_n && bus_oe_n && bus_rw && !bus_ale && !bus_ad_oe && !rsp_done && !rsp_err,
        "R12", "reset idle levels",
        {25'd0, busy, bus_cs_n, bus_oe_n, bus_rw, bus_ale, bus_ad_oe, rsp_done | rsp_err}, 32'h38);

    // R2 valid clear blocks everything
    set_cfg(32'h6000_0000, 16'h0007, 1'b0, 1, 1, 1'b0, 1'b0);
    access(1'b0, 32'h6000_0000, 32'd0, 2'd0);
    access(1'b1, 32'h6000_0010, 32'h1234_5678, 2'd2);

    // R1 window edges
    set_cfg(32'h6000_0000, 16'h0007, 1'b1, 1, 1, 1'b0, 1'b0);
    access(1'b0, 32'h6000_0000, 32'd0, 2'd0);
    access(1'b0, 32'h6007_FFFF, 32'd0, 2'd0);
    access(1'b0, 32'h6008_0000, 32'd0, 2'd0);  // R3 just above
    access(1'b1, 32'h5FFF_FFFF, 32'hA5, 2'd0); // R3 just below

    // R6 non-burst writes/reads of each size, R13 size code 3
    access(1'b1, 32'h6000_0020, 32'h8765_4321, 2'd2);
    access(1'b0, 32'h6000_0020, 32'd0, 2'd2);
    access(1'b1, 32'h6000_0012, 32'h0000_1234, 2'd1);
    access(1'b0, 32'h6000_0030, 32'd0, 2'd3);

    // R9 read burst only: reads burst, writes do not
    set_cfg(32'h6000_0000, 16'h0007, 1'b1, 0, 2, 1'b1, 1'b0);
    access(1'b0, 32'h6000_0040, 32'd0, 2'd2);
    access(1'b1, 32'h6000_0040, 32'hDEAD_BEEF, 2'd2);
    // R9 write burst only
    set_cfg(32'h6000_0000, 16'h0007, 1'b1, 3, 0, 1'b0, 1'b1);
    access(1'b1, 32'h6000_0050, 32'hCAFE_F00D, 2'd2);
    access(1'b0, 32'h6000_0052, 32'd0, 2'd1);

    // R8 single byte with both bursts on matches the plain trace
    set_cfg(32'h6000_0000, 16'h0007, 1'b1, 2, 3, 1'b1, 1'b1);
    access(1'b1, 32'h6000_0001, 32'h0000_005A, 2'd0);
    access(1'b0, 32'h6000_0002, 32'd0, 2'd0);
    access(1'b0, 32'h6000_0004, 32'd0, 2'd1);  // R7

    // random mix: R4/R5 ranges, all burst combinations, random masks
    for (int i = 0; i < 60; i++) begin
      if (i % 5 == 0)
        set_cfg(32'h6000_0000 & ~{16'($urandom), 16'hFFFF} | 32'h6000_0000,
                16'($urandom & 32'h00FF), 1'b1, int'($urandom % 4), int'($urandom % 16),
                1'($urandom), 1'($urandom));
      if ($urandom % 10 < 8) a = b_base | ($urandom & {b_mfield, 16'hFFFF});
      else a = $urandom;
      access(1'($urandom), a, $urandom, 2'($urandom));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule